// File: doc/BRIEF.md
# ACPI Embedded Controller Host Mailbox

This block is the mailbox between a host I/O bus and an embedded microcontroller, organised along the lines of the ACPI embedded controller model. On the host side it decodes two byte ports at a relocatable 12-bit base: a data port at the base, and a port four bytes above it that accepts commands on writes and returns the status byte on reads. On the controller side it offers an indexed register space with the activation and base-address configuration registers, one inbound register that both host data and host commands land in, an outbound data register, and the status register.

Host writes to either port land in the same inbound register. A hardware flag in the status byte records whether that write came through the command port or the data port. Two handshake flags track the inbound and outbound traffic, and each drives an interrupt line: one to the controller, one to the host.

Both sides use simple single-clock strobed interfaces. Read data is combinational in the cycle of the read strobe. Every side effect on flags and registers takes place at the clock edge that closes the access.

Top module: `ec_host_mailbox`

## Requirements
- R1: After reset the activate bit is 0, the base address is 0x062, the status byte is 0x00, the inbound register is 0x00, and both interrupt outputs are low.
- R2: Controller index 0x30 holds the activate flag in bit 0, and its other bits read 0. Index 0x60 holds base bits 11..8 in its low nibble, and its upper nibble reads 0. Index 0x61 holds base bits 7..0, and bits 0 and 2 always read 0 whatever was written.
- R3: While the activate bit is 0, no host access is claimed, host reads return 0xFF, and host writes change neither the inbound register nor the status byte.
- R4: While active, a host read at the base returns the outbound register, and a host read at base+4 returns the status byte. In both cases h_claim is high in the cycle of the strobe. An address with any bit above bit 11 set is not claimed.
- R5: A host write at the base loads the inbound register and clears CMD (status bit 3). A host write at base+4 loads the inbound register and sets CMD. The controller reads the inbound register at index 0x10.
- R6: IBF (status bit 1) is set in the cycle after any claimed host write. It is cleared in the cycle after a controller read of index 0x10. When both happen in the same cycle, the set wins.
- R7: OBF (status bit 0) is set in the cycle after a controller write to index 0x10, which loads the outbound register. It is cleared after a host read of the data port. When both happen in the same cycle, the set wins and the host reads the previous outbound value.
- R8: Status bits 2, 4, 5, 6 and 7 are written by the controller at index 0x11. Such writes leave bits 0, 1 and 3 unchanged.
- R9: irq_mcu is high exactly while IBF is set, and irq_host is high exactly while OBF is set.
- R10: After the base is reprogrammed, the old addresses are no longer claimed, and the new base and base+4 decode, up to the highest legal base 0xFFA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both interfaces |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_addr | input | 16 | Host I/O address |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, valid in the strobe cycle |
| h_claim | output | 1 | Access hits an active mailbox port |
| m_addr | input | 8 | Controller register index |
| m_wr | input | 1 | Controller write strobe |
| m_rd | input | 1 | Controller read strobe |
| m_wdata | input | 8 | Controller write data |
| m_rdata | output | 8 | Controller read data, valid in the strobe cycle |
| irq_mcu | output | 1 | Interrupt to controller while inbound is full |
| irq_host | output | 1 | Interrupt to host while outbound is full |

## Verification
Read data and h_claim are combinational, so they are due in the same cycle as the read strobe. The monitor compares them at the falling edge inside that strobe cycle. Flag, register and interrupt effects land on the rising edge that ends an access, so they are checked only by a later access or interrupt probe, after at least one full cycle. The same-cycle collision cases pair a host strobe with a controller strobe in one cycle. Each such case checks the old value in that cycle and the winning flag in the following access.

// File: rtl/ec_mbox_pkg.sv
package ec_mbox_pkg;
   localparam int unsigned BASE_W = 12;
   localparam int unsigned DAT_W  = 8;
   // command/status port sits this far above the data port; base bit 2 is forced low
   localparam logic [BASE_W-1:0] CMD_OFS    = 12'h004;
   localparam logic [BASE_W-1:0] BASE_FORCE = 12'h005;
   localparam int unsigned ST_OBF = 0;
   localparam int unsigned ST_IBF = 1;
   localparam int unsigned ST_CMD = 3;

   typedef struct packed {
      logic data_wr;
      logic cmd_wr;
      logic data_rd;
      logic stat_rd;
   } host_evt_t;
endpackage

// File: rtl/ec_mbox_cfg.sv
module ec_mbox_cfg
   import ec_mbox_pkg::*;
#(
   parameter int unsigned            MIDX_W   = 8,
   parameter logic [MIDX_W-1:0]      IDX_ACT  = 8'h30,
   parameter logic [MIDX_W-1:0]      IDX_BHI  = 8'h60,
   parameter logic [MIDX_W-1:0]      IDX_BLO  = 8'h61,
   parameter logic [BASE_W-1:0]      BASE_RST = 12'h062
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MIDX_W-1:0] m_addr,
   input  logic              m_wr,
   input  logic [DAT_W-1:0]  m_wdata,
   output logic              active,
   output logic [BASE_W-1:0] base,
   output logic              cfg_hit,
   output logic [DAT_W-1:0]  cfg_rdata
);
   localparam logic [BASE_W-1:0] BASE_INIT = BASE_RST & ~BASE_FORCE;

   if ((BASE_RST & BASE_FORCE) != '0) begin : g_bad_base
      $error("BASE_RST must have bits 0 and 2 clear");
   end
   if (IDX_ACT == IDX_BHI || IDX_ACT == IDX_BLO || IDX_BHI == IDX_BLO) begin : g_bad_idx
      $error("configuration indices must differ");
   end

   logic              act_q;
   logic [BASE_W-1:0] base_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         base_q <= BASE_INIT;
      end else if (m_wr) begin
         case (m_addr)
            IDX_ACT: act_q <= m_wdata[0];
            IDX_BHI: base_q[BASE_W-1:DAT_W] <= m_wdata[BASE_W-DAT_W-1:0];
            IDX_BLO: base_q[DAT_W-1:0] <= m_wdata & ~BASE_FORCE[DAT_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      cfg_hit   = 1'b1;
      cfg_rdata = '0;
      case (m_addr)
         IDX_ACT: cfg_rdata[0] = act_q;
         IDX_BHI: cfg_rdata[BASE_W-DAT_W-1:0] = base_q[BASE_W-1:DAT_W];
         IDX_BLO: cfg_rdata = base_q[DAT_W-1:0];
         default: cfg_hit = 1'b0;
      endcase
   end

   assign active = act_q;
   assign base   = base_q;

   assert_lo_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (m_wr && m_addr == IDX_BLO) |=> (!base_q[0] && !base_q[2]));
endmodule

// File: rtl/ec_mbox_decode.sv
module ec_mbox_decode
   import ec_mbox_pkg::*;
#(
   parameter int unsigned HADDR_W = 16
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               active,
   input  logic [BASE_W-1:0]  base,
   input  logic [HADDR_W-1:0] h_addr,
   input  logic               h_wr,
   input  logic               h_rd,
   output host_evt_t          evt,
   output logic               claim
);
   if (HADDR_W < BASE_W) begin : g_bad_width
      $error("HADDR_W must cover the 12-bit base");
   end

   logic upper_ok;
   if (HADDR_W > BASE_W) begin : g_wide
      assign upper_ok = ~|h_addr[HADDR_W-1:BASE_W];
   end else begin : g_exact
      assign upper_ok = 1'b1;
   end

   logic [BASE_W-1:0] low;
   logic              data_sel, cmd_sel;
   assign low      = h_addr[BASE_W-1:0];
   assign data_sel = active && upper_ok && (low == base);
   assign cmd_sel  = active && upper_ok && (low == (base | CMD_OFS));

   assign evt.data_wr = data_sel & h_wr;
   assign evt.cmd_wr  = cmd_sel  & h_wr;
   assign evt.data_rd = data_sel & h_rd;
   assign evt.stat_rd = cmd_sel  & h_rd;
   assign claim       = (data_sel | cmd_sel) & (h_wr | h_rd);

   // depends on the configuration block keeping base bit 2 low
   assert_one_port_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (evt.data_wr || evt.data_rd) |-> !(evt.cmd_wr || evt.stat_rd));
   assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> !claim);
endmodule

// File: rtl/ec_mbox_status.sv
module ec_mbox_status
   import ec_mbox_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  host_evt_t        evt,
   input  logic [DAT_W-1:0] h_wdata,
   input  logic             m_in_rd,
   input  logic             m_out_wr,
   input  logic             m_st_wr,
   input  logic [DAT_W-1:0] m_wdata,
   output logic [DAT_W-1:0] status,
   output logic [DAT_W-1:0] inbound,
   output logic [DAT_W-1:0] outbound
);
   logic             obf_q, ibf_q, cmd_q;
   logic [DAT_W-1:0] in_q, out_q;
   logic             host_wr;

   assign host_wr = evt.data_wr | evt.cmd_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_q  <= '0;
         cmd_q <= 1'b0;
         ibf_q <= 1'b0;
      end else if (host_wr) begin
         in_q  <= h_wdata;
         cmd_q <= evt.cmd_wr;
         ibf_q <= 1'b1;
      end else if (m_in_rd) begin
         ibf_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= '0;
         obf_q <= 1'b0;
      end else if (m_out_wr) begin
         out_q <= m_wdata;
         obf_q <= 1'b1;
      end else if (evt.data_rd) begin
         obf_q <= 1'b0;
      end
   end

   for (genvar b = 0; b < DAT_W; b++) begin : g_bit
      if (b == ST_OBF) begin : g_obf
         assign status[b] = obf_q;
      end else if (b == ST_IBF) begin : g_ibf
         assign status[b] = ibf_q;
      end else if (b == ST_CMD) begin : g_cmd
         assign status[b] = cmd_q;
      end else begin : g_fw
         logic fw_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       fw_q <= 1'b0;
            else if (m_st_wr) fw_q <= m_wdata[b];
         end
         assign status[b] = fw_q;
      end
   end

   assign inbound  = in_q;
   assign outbound = out_q;

   assert_data_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      evt.data_wr |=> (!status[ST_CMD] && status[ST_IBF]));
   assert_cmd_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      evt.cmd_wr |=> (status[ST_CMD] && status[ST_IBF]));
   assert_ibf_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (m_in_rd && !host_wr) |=> !status[ST_IBF]);
   assert_obf_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      m_out_wr |=> status[ST_OBF]);
   assert_obf_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (evt.data_rd && !m_out_wr) |=> !status[ST_OBF]);
   assert_hw_bits_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (m_st_wr && !host_wr && !m_in_rd && !m_out_wr && !evt.data_rd)
      |=> $stable({status[ST_OBF], status[ST_IBF], status[ST_CMD]}));
endmodule

// File: rtl/ec_host_mailbox.sv
module ec_host_mailbox
   import ec_mbox_pkg::*;
#(
   parameter int unsigned        HADDR_W    = 16,
   parameter int unsigned        MIDX_W     = 8,
   parameter logic [MIDX_W-1:0]  IDX_ACT    = 8'h30,
   parameter logic [MIDX_W-1:0]  IDX_BHI    = 8'h60,
   parameter logic [MIDX_W-1:0]  IDX_BLO    = 8'h61,
   parameter logic [MIDX_W-1:0]  IDX_MBOX   = 8'h10,
   parameter logic [MIDX_W-1:0]  IDX_STAT   = 8'h11,
   parameter logic [BASE_W-1:0]  BASE_RST   = 12'h062,
   parameter logic [DAT_W-1:0]   IDLE_RDATA = 8'hFF
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [HADDR_W-1:0] h_addr,
   input  logic               h_wr,
   input  logic               h_rd,
   input  logic [DAT_W-1:0]   h_wdata,
   output logic [DAT_W-1:0]   h_rdata,
   output logic               h_claim,
   input  logic [MIDX_W-1:0]  m_addr,
   input  logic               m_wr,
   input  logic               m_rd,
   input  logic [DAT_W-1:0]   m_wdata,
   output logic [DAT_W-1:0]   m_rdata,
   output logic               irq_mcu,
   output logic               irq_host
);
   if (IDX_MBOX == IDX_STAT || IDX_MBOX == IDX_ACT || IDX_MBOX == IDX_BHI ||
       IDX_MBOX == IDX_BLO || IDX_STAT == IDX_ACT || IDX_STAT == IDX_BHI ||
       IDX_STAT == IDX_BLO) begin : g_bad_idx
      $error("mailbox indices collide with configuration indices");
   end

   logic              active, cfg_hit;
   logic [BASE_W-1:0] base;
   logic [DAT_W-1:0]  cfg_rdata, status, inbound, outbound;
   host_evt_t         evt;
   logic              m_in_rd, m_out_wr, m_st_wr;

   assign m_in_rd  = m_rd && (m_addr == IDX_MBOX);
   assign m_out_wr = m_wr && (m_addr == IDX_MBOX);
   assign m_st_wr  = m_wr && (m_addr == IDX_STAT);

   ec_mbox_cfg #(
      .MIDX_W(MIDX_W), .IDX_ACT(IDX_ACT), .IDX_BHI(IDX_BHI),
      .IDX_BLO(IDX_BLO), .BASE_RST(BASE_RST)
   ) i_cfg (
      .clk(clk), .rst_n(rst_n), .m_addr(m_addr), .m_wr(m_wr), .m_wdata(m_wdata),
      .active(active), .base(base), .cfg_hit(cfg_hit), .cfg_rdata(cfg_rdata)
   );

   ec_mbox_decode #(.HADDR_W(HADDR_W)) i_dec (
      .clk(clk), .rst_n(rst_n), .active(active), .base(base),
      .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd), .evt(evt), .claim(h_claim)
   );

   ec_mbox_status i_stat (
      .clk(clk), .rst_n(rst_n), .evt(evt), .h_wdata(h_wdata),
      .m_in_rd(m_in_rd), .m_out_wr(m_out_wr), .m_st_wr(m_st_wr), .m_wdata(m_wdata),
      .status(status), .inbound(inbound), .outbound(outbound)
   );

   always_comb begin
      if (evt.data_rd)      h_rdata = outbound;
      else if (evt.stat_rd) h_rdata = status;
      else                  h_rdata = IDLE_RDATA;
   end

   always_comb begin
      if (cfg_hit)                 m_rdata = cfg_rdata;
      else if (m_addr == IDX_MBOX) m_rdata = inbound;
      else if (m_addr == IDX_STAT) m_rdata = status;
      else                         m_rdata = '0;
   end

   assign irq_mcu  = status[ST_IBF];
   assign irq_host = status[ST_OBF];

   assert_inactive_rdata_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && h_rd) |-> (h_rdata == IDLE_RDATA && !h_claim));
   assert_mcu_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (h_claim && h_wr) |=> irq_mcu);
endmodule

// File: tb/test_ec_host_mailbox.sv
`timescale 1ns/1ps
module test_ec_host_mailbox;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] h_addr = '0;
   logic        h_wr = 1'b0, h_rd = 1'b0;
   logic [7:0]  h_wdata = '0;
   logic [7:0]  h_rdata;
   logic        h_claim;
   logic [7:0]  m_addr = '0;
   logic        m_wr = 1'b0, m_rd = 1'b0;
   logic [7:0]  m_wdata = '0;
   logic [7:0]  m_rdata;
   logic        irq_mcu, irq_host;
   logic        probe = 1'b0;
   int          checks = 0, errors = 0, cycles = 0;
   bit          done = 1'b0;

   typedef struct {
      int         src;
      logic [8:0] exp;
      string      req;
   } item_t;
   item_t sb[$];

   always #2 clk = ~clk;

   ec_host_mailbox i_ec_host_mailbox (
      .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd),
      .h_wdata(h_wdata), .h_rdata(h_rdata), .h_claim(h_claim), .m_addr(m_addr),
      .m_wr(m_wr), .m_rd(m_rd), .m_wdata(m_wdata), .m_rdata(m_rdata),
      .irq_mcu(irq_mcu), .irq_host(irq_host)
   );

   task automatic push(input int src, input logic [8:0] exp, input string req);
      item_t it;
      it.src = src; it.exp = exp; it.req = req;
      sb.push_back(it);
   endtask

   task automatic compare(input int src, input logic [8:0] got);
      item_t it;
      checks++;
      if (sb.size() == 0) begin
         errors++;
         $display("FAIL scoreboard: unexpected result src %0d got %h expected none", src, got);
      end else begin
         it = sb.pop_front();
         if (it.src != src || it.exp !== got) begin
            errors++;
            $display("FAIL %s: src %0d got %h expected %h (src %0d)",
                     it.req, src, got, it.exp, it.src);
         end
      end
   endtask

   // monitor: results are combinational within the strobe cycle
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (h_rd)  compare(0, {h_claim, h_rdata});
         if (m_rd)  compare(1, {1'b0, m_rdata});
         if (probe) compare(2, {7'b0, irq_host, irq_mcu});
      end
   end

   task automatic host_rd(input logic [15:0] a, input logic cl, input logic [7:0] d, input string req);
      @(posedge clk); #1;
      h_addr = a; h_rd = 1'b1; push(0, {cl, d}, req);
      @(posedge clk); #1;
      h_rd = 1'b0;
   endtask

   task automatic host_wr(input logic [15:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      h_addr = a; h_wdata = d; h_wr = 1'b1;
      @(posedge clk); #1;
      h_wr = 1'b0;
   endtask

   task automatic mcu_rd(input logic [7:0] idx, input logic [7:0] d, input string req);
      @(posedge clk); #1;
      m_addr = idx; m_rd = 1'b1; push(1, {1'b0, d}, req);
      @(posedge clk); #1;
      m_rd = 1'b0;
   endtask

   task automatic mcu_wr(input logic [7:0] idx, input logic [7:0] d);
      @(posedge clk); #1;
      m_addr = idx; m_wdata = d; m_wr = 1'b1;
      @(posedge clk); #1;
      m_wr = 1'b0;
   endtask

   task automatic irq_probe(input logic [1:0] e, input string req);
      @(posedge clk); #1;
      probe = 1'b1; push(2, {7'b0, e}, req);
      @(posedge clk); #1;
      probe = 1'b0;
   endtask

   // host write and controller mailbox read in one cycle
   task automatic hwr_mrd(input logic [15:0] a, input logic [7:0] d, input logic [7:0] e, input string req);
      @(posedge clk); #1;
      h_addr = a; h_wdata = d; h_wr = 1'b1;
      m_addr = 8'h10; m_rd = 1'b1; push(1, {1'b0, e}, req);
      @(posedge clk); #1;
      h_wr = 1'b0; m_rd = 1'b0;
   endtask

   // controller outbound write and host data read in one cycle
   task automatic mwr_hrd(input logic [7:0] d, input logic [15:0] a, input logic [7:0] e, input string req);
      @(posedge clk); #1;
      m_addr = 8'h10; m_wdata = d; m_wr = 1'b1;
      h_addr = a; h_rd = 1'b1; push(0, {1'b1, e}, req);
      @(posedge clk); #1;
      m_wr = 1'b0; h_rd = 1'b0;
   endtask

   task automatic finish_run;
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles == 20000 && !done) begin
         checks++; errors++;
         $display("FAIL watchdog: got %0d cycles expected completion", cycles);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      irq_probe(2'b00, "R1 irq at reset");
      mcu_rd(8'h30, 8'h00, "R1 activate");
      mcu_rd(8'h60, 8'h00, "R1 base high");
      mcu_rd(8'h61, 8'h62, "R1 base low");
      mcu_rd(8'h11, 8'h00, "R1 status");
      mcu_rd(8'h10, 8'h00, "R1 inbound");
      // R3 inactive
      host_rd(16'h0062, 1'b0, 8'hFF, "R3 inactive read");
      host_wr(16'h0062, 8'h5A);
      host_wr(16'h0066, 8'hA5);
      mcu_rd(8'h11, 8'h00, "R3 status untouched");
      mcu_rd(8'h10, 8'h00, "R3 inbound untouched");
      // R2 configuration masks
      mcu_wr(8'h30, 8'hFF);
      mcu_rd(8'h30, 8'h01, "R2 activate mask");
      mcu_wr(8'h60, 8'hFF);
      mcu_rd(8'h60, 8'h0F, "R2 high nibble");
      mcu_wr(8'h61, 8'hFF);
      mcu_rd(8'h61, 8'hFA, "R2 low forced bits");
      mcu_wr(8'h60, 8'h00);
      mcu_wr(8'h61, 8'h62);
      // R5 R6 data write
      host_wr(16'h0062, 8'h3C);
      mcu_rd(8'h11, 8'h02, "R6 IBF set, R5 CMD clear");
      irq_probe(2'b01, "R9 irq_mcu");
      mcu_rd(8'h10, 8'h3C, "R5 inbound data");
      mcu_rd(8'h11, 8'h00, "R6 IBF cleared");
      // R5 command write, R4 status read
      host_wr(16'h0066, 8'h81);
      host_rd(16'h0066, 1'b1, 8'h0A, "R4 status read, R5 CMD set");
      mcu_rd(8'h10, 8'h81, "R5 inbound command");
      host_rd(16'h0066, 1'b1, 8'h08, "R6 IBF cleared, CMD kept");
      // R7 outbound
      mcu_wr(8'h10, 8'hC3);
      host_rd(16'h0066, 1'b1, 8'h09, "R7 OBF set");
      irq_probe(2'b10, "R9 irq_host");
      host_rd(16'h0062, 1'b1, 8'hC3, "R4 data read");
      host_rd(16'h0066, 1'b1, 8'h08, "R7 OBF cleared");
      // R8 firmware bits
      mcu_wr(8'h11, 8'hFF);
      mcu_rd(8'h11, 8'hFC, "R8 firmware bits set");
      mcu_wr(8'h11, 8'h00);
      mcu_rd(8'h11, 8'h08, "R8 hardware bits kept");
      // R4 upper address bits
      host_rd(16'h1062, 1'b0, 8'hFF, "R4 upper bits reject");
      // R10 relocation
      mcu_wr(8'h60, 8'h0A);
      mcu_wr(8'h61, 8'hB8);
      host_rd(16'h0062, 1'b0, 8'hFF, "R10 old base dropped");
      host_rd(16'h0AB8, 1'b1, 8'hC3, "R10 new data port");
      host_rd(16'h0ABC, 1'b1, 8'h08, "R10 new status port");
      mcu_wr(8'h60, 8'h0F);
      mcu_wr(8'h61, 8'hFA);
      host_wr(16'h0FFE, 8'h11);
      mcu_rd(8'h11, 8'h0A, "R10 top base command");
      // R6 collision: set wins
      hwr_mrd(16'h0FFA, 8'h77, 8'h11, "R6 collision old inbound");
      mcu_rd(8'h11, 8'h02, "R6 collision IBF stays");
      mcu_rd(8'h10, 8'h77, "R6 collision new inbound");
      // R7 collision: set wins
      mwr_hrd(8'h5E, 16'h0FFA, 8'hC3, "R7 collision old outbound");
      host_rd(16'h0FFE, 1'b1, 8'h01, "R7 collision OBF stays");
      irq_probe(2'b10, "R9 irq after collision");
      host_rd(16'h0FFA, 1'b1, 8'h5E, "R7 new outbound");
      host_rd(16'h0FFE, 1'b1, 8'h00, "R7 OBF cleared");
      repeat (3) @(posedge clk);
      if (sb.size() != 0) begin
         checks++; errors++;
         $display("FAIL scoreboard: got %0d pending expected 0", sb.size());
      end
      finish_run();
   end
endmodule